// File: doc/BRIEF.md
# Half-Duplex Back-Pressure Jam Controller

This block applies back-pressure flow control on the transmit side of a half-duplex Ethernet MAC. When a nonzero flow-control mode is selected, it fills the medium with a byte stream of alternating ones and zeros. Other stations then either defer or collide, so traffic towards the local station is held off.

When the local transmitter raises a frame request during jamming, the controller ends the jam on a byte boundary. It then keeps the line quiet for one inter-packet gap of 96 bit times, which is twelve byte clocks, and grants the medium. After the transmitter reports that the frame is done, the controller inserts one turnaround byte time. It then restarts jamming, provided the mode is still nonzero. Collision handling, backoff and PHY signalling belong to neighbouring blocks.

Top module: `bpj_backpressure`

## Requirements
- R1: During and directly after a synchronous active-high reset, tx_valid, frame_grant and tx_data are all zero.
- R2: With fc_mode equal to 2'b00 and the block idle, tx_valid stays low. A nonzero fc_mode seen at a clock edge while idle makes tx_valid high from the next cycle on.
- R3: Every byte presented with tx_valid high is 8'h55. tx_data is 8'h00 whenever tx_valid is low.
- R4: A frame_req seen at a clock edge while jamming ends the jam at that edge. No partial byte is produced, and tx_valid is low in the following cycle.
- R5: After a jam ends for a frame, exactly 12 cycles pass with both tx_valid and frame_grant low, and then frame_grant rises.
- R6: frame_grant stays high until tx_done is seen and falls at the next edge. No jam byte appears from the start of the gap until that edge.
- R7: After the cycle in which frame_grant falls, jamming resumes in the next cycle if fc_mode is then nonzero.
- R8: If fc_mode becomes 2'b00 during the gap or the frame, the gap and the frame still complete. The block then returns to idle, and no jam byte follows.
- R9: fc_mode set to 2'b00 while jamming stops the jam at the next edge.
- R10: frame_req has no effect while the block is idle with fc_mode 2'b00: frame_grant stays low and tx_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_mode | input | 2 | Flow-control mode; 2'b00 disables jamming, other values enable it |
| frame_req | input | 1 | Local transmitter has a frame ready |
| tx_done | input | 1 | Local transmitter finished its frame |
| frame_grant | output | 1 | Medium handed to the local transmitter |
| tx_data | output | 8 | Jam byte towards the medium |
| tx_valid | output | 1 | tx_data carries a jam byte this cycle |

## Verification
The assertions assume that the transmitter holds frame_req from the moment it raises it until it is granted. They also assume that tx_done is asserted only for a single cycle while frame_grant is high. The random driver keeps to these rules. It raises a request only when none is pending, decides on tx_done only after seeing frame_grant, and drops frame_req in the same cycle as tx_done. Mode changes are random and may land in any state, including the gap and the frame, so that R8 and R9 are exercised. Directed cases cover the exact gap length and a request made with jamming disabled.

// File: rtl/bpj_pkg.sv
package bpj_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_JAM     = 3'd1,
        ST_GAP     = 3'd2,
        ST_XMIT    = 3'd3,
        ST_POSTGAP = 3'd4
    } bpj_state_e;

    typedef struct packed {
        bpj_state_e state;
    } bpj_regs_t;

endpackage

// File: rtl/bpj_gap_timer.sv
module bpj_gap_timer #(
    parameter int GAP_BYTES = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CW = (GAP_BYTES < 2) ? 1 : $clog2(GAP_BYTES);
    localparam logic [CW-1:0] LAST = CW'(GAP_BYTES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run ? cnt_q + 1'b1 : '0;
        done  = run && (cnt_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // R5: the count never runs past the last gap byte
    a_r5_count_bounded: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt_q <= LAST);

    // R5: leaving run clears the count for the next gap
    a_r5_count_clears: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt_q == '0);

endmodule

// File: rtl/bpj_jam_src.sv
module bpj_jam_src #(
    parameter int                 DATA_W   = 8,
    parameter logic [DATA_W-1:0]  JAM_BYTE = 8'h55
) (
    input  logic              en,
    output logic [DATA_W-1:0] data,
    output logic              valid
);
    always_comb begin
        valid = en;
        data  = en ? JAM_BYTE : '0;
    end
endmodule

// File: rtl/bpj_backpressure.sv
module bpj_backpressure
    import bpj_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] JAM_BYTE  = 8'h55,
    parameter int                GAP_BYTES = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        fc_mode,
    input  logic              frame_req,
    input  logic              tx_done,
    output logic              frame_grant,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_valid
);
    localparam int QW = $clog2(GAP_BYTES + 2) + 1;
    localparam logic [QW-1:0] Q_GAP = QW'(GAP_BYTES);
    localparam logic [QW-1:0] Q_SAT = QW'(GAP_BYTES + 1);

    bpj_regs_t r_d, r_q;
    logic      fc_on;
    logic      gap_done;

    assign fc_on = (fc_mode != 2'b00);

    bpj_gap_timer #(.GAP_BYTES(GAP_BYTES)) u_gap (
        .clk  (clk),
        .rst  (rst),
        .run  (r_q.state == ST_GAP),
        .done (gap_done)
    );

    bpj_jam_src #(.DATA_W(DATA_W), .JAM_BYTE(JAM_BYTE)) u_src (
        .en    (r_q.state == ST_JAM),
        .data  (tx_data),
        .valid (tx_valid)
    );

    assign frame_grant = (r_q.state == ST_XMIT);

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE:    if (fc_on) r_d.state = ST_JAM;
            ST_JAM: begin
                if (!fc_on)         r_d.state = ST_IDLE;
                else if (frame_req) r_d.state = ST_GAP;
            end
            ST_GAP:     if (gap_done) r_d.state = ST_XMIT;
            ST_XMIT:    if (tx_done)  r_d.state = ST_POSTGAP;
            ST_POSTGAP: r_d.state = fc_on ? ST_JAM : ST_IDLE;
            default:    r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q.state <= ST_IDLE;
        else     r_q       <= r_d;
    end

    // Quiet-run counter used only by the gap-length check
    logic [QW-1:0] quiet_q;
    always_ff @(posedge clk) begin
        if (rst)                          quiet_q <= '0;
        else if (tx_valid || frame_grant) quiet_q <= '0;
        else if (quiet_q != Q_SAT)        quiet_q <= quiet_q + 1'b1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !tx_valid && !frame_grant);

    a_r2_idle_off: assert property (@(posedge clk) disable iff (rst)
        (!tx_valid && !frame_grant && !fc_on && r_q.state == ST_IDLE) |=> !tx_valid);

    a_r3_pattern: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> tx_data == JAM_BYTE);

    a_r4_stop_on_req: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && frame_req) |=> !tx_valid && !frame_grant);

    a_r5_gap_exact: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_grant) |-> quiet_q == Q_GAP);

    a_r6_no_jam_with_grant: assert property (@(posedge clk) disable iff (rst)
        !(frame_grant && tx_valid));

    a_r6_grant_release: assert property (@(posedge clk) disable iff (rst)
        (frame_grant && tx_done) |=> !frame_grant && !tx_valid);

    a_r9_stop_on_off: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !fc_on) |=> !tx_valid);

endmodule

// File: tb/sim_bpj_backpressure.sv
`timescale 1ns/1ps
module sim_bpj_backpressure;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] fc_mode = 2'b00;
    logic       frame_req = 1'b0;
    logic       tx_done = 1'b0;
    logic       frame_grant;
    logic [7:0] tx_data;
    logic       tx_valid;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    bpj_backpressure u0 (
        .clk(clk), .rst(rst), .fc_mode(fc_mode), .frame_req(frame_req),
        .tx_done(tx_done), .frame_grant(frame_grant), .tx_data(tx_data),
        .tx_valid(tx_valid)
    );

    // Reference built from the requirements: 0 idle,1 jam,2 gap,3 frame,4 turnaround
    int m_st = 0;
    int m_cnt = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_st <= 0; m_cnt <= 0;
        end else begin
            case (m_st)
                0: if (fc_mode != 0) m_st <= 1;
                1: begin
                    if (fc_mode == 0) m_st <= 0;
                    else if (frame_req) begin m_st <= 2; m_cnt <= 0; end
                end
                2: begin
                    if (m_cnt == 11) m_st <= 3;
                    m_cnt <= m_cnt + 1;
                end
                3: if (tx_done) m_st <= 4;
                default: m_st <= (fc_mode != 0) ? 1 : 0;
            endcase
        end
    end

    function automatic logic exp_valid(int st); return st == 1; endfunction
    function automatic logic exp_grant(int st); return st == 3; endfunction
    function automatic logic [7:0] exp_data(int st); return (st == 1) ? 8'h55 : 8'h00; endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h time=%0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the reference, away from the edge
    always @(negedge clk) begin
        if (rst) begin
            check("R1 valid", tx_valid, 0);
            check("R1 grant", frame_grant, 0);
            check("R1 data", tx_data, 0);
        end else if (!finished) begin
            check((m_st == 2 || m_st == 3) ? "R6 valid" : "R2 valid", tx_valid, exp_valid(m_st));
            check("R5 grant", frame_grant, exp_grant(m_st));
            check("R3 data", tx_data, exp_data(m_st));
        end
    end

    task automatic step(); @(posedge clk); #1; endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    int quiet;
    int jams;
    int grants;
    int flen;

    initial begin
        void'($urandom(32'd1234));
        repeat (3) step();
        rst = 1'b0;

        // R10: request while disabled is ignored
        frame_req = 1'b1;
        grants = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (frame_grant || tx_valid) grants++;
        end
        check("R10 no grant or jam while off", grants, 0);
        step(); frame_req = 1'b0;

        // R2: enable jamming, first jam byte one cycle after the edge
        fc_mode = 2'b01;
        @(negedge clk);
        check("R2 not yet jamming", tx_valid, 0);
        @(negedge clk);
        check("R2 jamming", tx_valid, 1);
        check("R3 pattern", tx_data, 8'h55);

        // R4/R5: exact gap, no jam byte before grant
        step(); frame_req = 1'b1;
        @(negedge clk);
        check("R4 last jam byte completes", tx_valid, 1);
        quiet = 0; jams = 0;
        for (int i = 0; i < 30 && !frame_grant; i++) begin
            @(negedge clk);
            if (tx_valid) jams++;
            else if (!frame_grant) quiet++;
        end
        check("R5 gap length", quiet, 12);
        check("R6 no jam in gap", jams, 0);
        check("R5 granted", frame_grant, 1);

        // R6/R7: finish the frame, resume jamming after one turnaround cycle
        step(); step();
        tx_done = 1'b1; frame_req = 1'b0;
        step(); tx_done = 1'b0;
        @(negedge clk);
        check("R6 grant released", frame_grant, 0);
        check("R7 turnaround quiet", tx_valid, 0);
        @(negedge clk);
        check("R7 jamming resumed", tx_valid, 1);

        // R8: disable during the gap, frame still served, no jam afterwards
        step(); frame_req = 1'b1;
        step(); step(); fc_mode = 2'b00;
        while (!frame_grant) step();
        check("R8 frame granted after disable", frame_grant, 1);
        tx_done = 1'b1; frame_req = 1'b0;
        step(); tx_done = 1'b0;
        jams = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (tx_valid) jams++;
        end
        check("R8 stays idle", jams, 0);

        // R9: disable while jamming
        step(); fc_mode = 2'b11;
        step(); step();
        fc_mode = 2'b00;
        @(negedge clk);
        check("R9 last jam byte", tx_valid, 1);
        @(negedge clk);
        check("R9 jam stopped", tx_valid, 0);

        // Random traffic with mode changes, compared against the reference
        flen = 0;
        for (int i = 0; i < 4000; i++) begin
            step();
            tx_done = 1'b0;
            if (frame_grant) begin
                if (flen == 0) begin tx_done = 1'b1; frame_req = 1'b0; end
                else flen--;
            end else if (!frame_req && ($urandom % 8) == 0) begin
                frame_req = 1'b1;
                flen = $urandom % 10;
            end
            if (($urandom % 48) == 0) fc_mode = 2'($urandom % 4);
        end

        step();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule